// File: doc/BRIEF.md
# Byte-Wide SPI Master with Two-Stage Clock Divider

This block is a single-lane SPI master that moves one byte at a time in both directions. Software reaches it through a small 32-bit register window. It programs the serial clock rate, the clock polarity and phase, and the chip-select level. It then writes a byte to start an exchange and reads the returned byte once a flag says it has arrived.

The serial clock comes from a coarse prescaler followed by a fine even divider. The coarse stage divides by 16 or by 128. The fine stage divides by 2*(N+1) for a 5-bit N. The chip-select pin is never sequenced by the shifter. It follows a level bit that software writes, and it is held inactive while the master-enable bit is clear. All four clock modes are supported. Bits are sent and received MSB first.

Top module: `spi_byte_master`

## Requirements
- R1: After reset every readable register reads 0, `spi_cs_n` is 1, `spi_sclk` is 0 and the shifter is idle.
- R2: The system register at offset 0x08 holds an 8-bit value. Bit 0 is master enable and bit 6 is the chip-select level. `spi_cs_n` is 1 when bit 0 is 0, and otherwise it equals bit 6, so writing 0x21 drives it low.
- R3: Control register (offset 0x00) bits 4:0 hold N and bit 5 picks the prescale, 128 when 1 and 16 when 0. Each half period of `spi_sclk` lasts prescale*(N+1) clock cycles. The first edge comes one half period after the clock edge that accepts the transmit write.
- R4: Control bit 6 is CPOL and bit 7 is CPHA. `spi_sclk` rests at CPOL whenever no exchange is running. Each exchange makes exactly 16 `spi_sclk` transitions.
- R5: `spi_mosi` carries the transmitted byte MSB first. It is valid at the sampling edges: the leading edges when CPHA is 0, and the trailing edges when CPHA is 1.
- R6: The byte on `spi_miso`, sampled on those same edges, is read MSB first from the receive buffer (offset 0x10) in bits 7:0. The upper bits read as 0.
- R7: Status (offset 0x04) bit 0 is set from the clock edge that accepts a transmit write (offset 0x0C) until the exchange ends.
- R8: Status bit 2 is set when an exchange ends. It is cleared by a read of the receive buffer or by any write to the status register.
- R9: A transmit write is ignored while status bit 0 is set, and also while master enable is 0. It starts no exchange and does not change the byte in flight.
- R10: A control write is ignored while an exchange is running, and the register keeps its earlier value.
- R11: The control and system registers read back what was written. The transmit register, offset 0x14 and any unmapped offset read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only) |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, low active |

## Verification
The bench models a slave that answers in whatever mode is programmed. Any design that mixes up launch and sample edges for one CPHA setting returns a shifted byte or loses the first bit. The bench times the first serial edge and the span of the whole exchange, so an off-by-one in either divider stage, or a swapped prescale select, shows up as a wrong cycle count. A second transmit write during an exchange is checked to make sure it neither restarts nor corrupts the transfer. A control write during an exchange is checked to make sure it does not stick. The bench also checks the chip-select truth table when the enable bit is off, and both ways of clearing the receive-full flag.

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 128,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  localparam int DIV_W    = 5;
  localparam int HALF_MAX = PRE_HI * (2 ** DIV_W);
  localparam int CW       = $clog2(HALF_MAX);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_SYS  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_TX   = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_RX   = ADDR_W'(8'h10);

  logic [7:0]    ctrl_q, sys_q, rx_q, sh_out, sh_in;
  logic          busy, rx_full, phase, mosi_q;
  logic [3:0]    edge_cnt;
  logic [CW-1:0] div_cnt;
  logic [CW:0]   half_len;

  wire cpha    = ctrl_q[7];
  wire cpol    = ctrl_q[6];
  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire wr_stat = bus_wr && bus_addr == A_STAT;
  wire wr_sys  = bus_wr && bus_addr == A_SYS;
  wire wr_tx   = bus_wr && bus_addr == A_TX;
  wire rd_rx   = bus_rd && bus_addr == A_RX;
  wire start   = wr_tx && !busy && sys_q[0];

  assign half_len = (ctrl_q[5] ? (CW+1)'(PRE_HI) : (CW+1)'(PRE_LO))
                  * ((CW+1)'(ctrl_q[DIV_W-1:0]) + (CW+1)'(1));

  wire       tick     = busy && ({1'b0, div_cnt} == half_len - (CW+1)'(1));
  wire       leading  = ~edge_cnt[0];
  wire       samp_now = tick && (leading ^ cpha);
  wire       shft_now = tick && !(leading ^ cpha);
  wire       last     = tick && edge_cnt == 4'd15;
  wire [7:0] sh_in_nx = {sh_in[6:0], spi_miso};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sys_q  <= '0;
    end else begin
      if (wr_ctrl && !busy) ctrl_q <= bus_wdata[7:0];
      if (wr_sys)           sys_q  <= bus_wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      phase    <= 1'b0;
      edge_cnt <= '0;
      div_cnt  <= '0;
      sh_out   <= '0;
      sh_in    <= '0;
      mosi_q   <= 1'b0;
    end else if (start) begin
      busy     <= 1'b1;
      phase    <= 1'b0;
      edge_cnt <= '0;
      div_cnt  <= '0;
      sh_out   <= bus_wdata[7:0];
      sh_in    <= '0;
      mosi_q   <= bus_wdata[7];
    end else if (busy) begin
      if (tick) begin
        div_cnt  <= '0;
        phase    <= ~phase;
        edge_cnt <= edge_cnt + 4'd1;
        if (samp_now) sh_in <= sh_in_nx;
        if (shft_now) begin
          mosi_q <= cpha ? sh_out[7] : sh_out[6];
          sh_out <= {sh_out[6:0], 1'b0};
        end
        if (last) busy <= 1'b0;
      end else begin
        div_cnt <= div_cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q    <= '0;
      rx_full <= 1'b0;
    end else if (last) begin
      rx_q    <= samp_now ? sh_in_nx : sh_in;
      rx_full <= 1'b1;
    end else if (wr_stat || rd_rx) begin
      rx_full <= 1'b0;
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_CTRL:  bus_rdata = {24'd0, ctrl_q};
      A_STAT:  bus_rdata = {29'd0, rx_full, 1'b0, busy};
      A_SYS:   bus_rdata = {24'd0, sys_q};
      A_RX:    bus_rdata = {24'd0, rx_q};
      default: bus_rdata = 32'd0;
    endcase
  end

  assign spi_sclk = phase ^ cpol;
  assign spi_mosi = mosi_q;
  assign spi_cs_n = ~sys_q[0] | sys_q[6];

  assert_cs_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_cs_n) |-> $past(wr_sys));
  assert_phase_home_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !phase);
  assert_busy_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_tx && sys_q[0]));
  assert_rxfull_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $fell(busy));
  assert_ctrl_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ctrl_q));
endmodule

// File: tb/spi_byte_master_tb.sv
module spi_byte_master_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        spi_sclk, spi_mosi, spi_cs_n;
  logic        spi_miso = 1'b0;

  int n_cmp = 0, n_err = 0;
  bit done_flag = 0;

  spi_byte_master u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  // slave model
  logic       m_cpol = 0, m_cpha = 0;
  logic [7:0] m_pat = 0, m_cap = 0;
  int         m_idx = 0, m_edges = 0;
  time        t_first = 0, t_last = 0, t_wr = 0;

  always @(spi_sclk) begin
    m_edges++;
    if (m_edges == 1) t_first = $time;
    t_last = $time;
    if ((spi_sclk != m_cpol) ^ m_cpha) m_cap = {m_cap[6:0], spi_mosi};
    else if (m_idx >= 0) begin spi_miso = m_pat[m_idx]; m_idx--; end
  end

  task automatic prep(input logic [7:0] ctrl, input logic [7:0] pat);
    m_cpol = ctrl[6]; m_cpha = ctrl[7]; m_pat = pat; m_cap = 0; m_edges = 0;
    if (ctrl[7]) begin m_idx = 7; spi_miso = 1'b0; end
    else begin spi_miso = pat[7]; m_idx = 6; end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); t_wr = $time;
    #1 bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      bus_read(5'h04, s);
      if (s[0] == 1'b0) break;
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  endtask

  // {ctrl, tx, slave pattern}
  localparam logic [23:0] VEC [0:6] = '{
    24'h00_A5_3C, 24'h40_81_C3, 24'h80_5A_96, 24'hC0_FF_00,
    24'h23_01_80, 24'hE2_7E_E7, 24'h1F_00_FF };

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    bus_read(5'h00, r); check("R1 ctrl", r, 0);
    bus_read(5'h04, r); check("R1 status", r, 0);
    bus_read(5'h08, r); check("R1 sys", r, 0);
    bus_read(5'h10, r); check("R1 rx", r, 0);
    check("R1 cs_n", {31'd0, spi_cs_n}, 1);
    check("R1 sclk", {31'd0, spi_sclk}, 0);

    // R2 chip select
    bus_write(5'h08, 32'h01); #1 check("R2 en cs low", {31'd0, spi_cs_n}, 0);
    bus_write(5'h08, 32'h41); #1 check("R2 level high", {31'd0, spi_cs_n}, 1);
    bus_write(5'h08, 32'h40); #1 check("R2 disabled", {31'd0, spi_cs_n}, 1);
    bus_write(5'h08, 32'h20); #1 check("R2 disabled lvl0", {31'd0, spi_cs_n}, 1);

    // R9 transmit ignored while disabled
    bus_write(5'h0C, 32'h55);
    bus_read(5'h04, r); check("R9 no start when disabled", r, 0);

    bus_write(5'h08, 32'h21); #1 check("R2 0x21 cs low", {31'd0, spi_cs_n}, 0);
    bus_read(5'h08, r); check("R11 sys readback", r, 32'h21);

    foreach (VEC[k]) begin
      logic [7:0] c, tx, pat;
      int half;
      {c, tx, pat} = VEC[k];
      half = (c[5] ? 128 : 16) * (int'(c[4:0]) + 1);
      bus_write(5'h00, {24'd0, c});
      bus_read(5'h00, r); check("R11 ctrl readback", r, {24'd0, c});
      check("R4 idle level", {31'd0, spi_sclk}, {31'd0, c[6]});
      prep(c, pat);
      bus_write(5'h0C, {24'd0, tx});
      bus_read(5'h04, r); check("R7 busy set", {31'd0, r[0]}, 1);
      wait_idle();
      check("R4 edge count", m_edges, 16);
      check("R3 first edge", 32'(t_first - t_wr), 32'(half * CLK_PERIOD));
      check("R3 span", 32'(t_last - t_first), 32'(15 * half * CLK_PERIOD));
      check("R5 mosi byte", {24'd0, m_cap}, {24'd0, tx});
      check("R4 sclk home", {31'd0, spi_sclk}, {31'd0, c[6]});
      bus_read(5'h04, r); check("R8 rx full", r, 32'h4);
      bus_read(5'h10, r); check("R6 rx byte", r, {24'd0, pat});
      bus_read(5'h04, r); check("R8 read clears", r, 0);
    end

    // R9 transmit during exchange, R10 control during exchange
    bus_write(5'h00, 32'h00);
    prep(8'h00, 8'h69);
    bus_write(5'h0C, 32'hC3);
    repeat (40) @(posedge clk);
    bus_write(5'h0C, 32'h18);
    bus_write(5'h00, 32'hC5);
    wait_idle();
    check("R9 byte kept", {24'd0, m_cap}, 32'hC3);
    check("R9 no restart", m_edges, 16);
    bus_read(5'h00, r); check("R10 ctrl kept", r, 0);
    bus_read(5'h10, r); check("R6 rx after overlap", r, 32'h69);

    // R8 status write clears
    prep(8'h00, 8'h0F);
    bus_write(5'h0C, 32'hF0);
    wait_idle();
    bus_read(5'h04, r); check("R8 full again", r, 32'h4);
    bus_write(5'h04, 32'h0);
    bus_read(5'h04, r); check("R8 status write clears", r, 0);
    bus_read(5'h10, r); check("R6 rx kept", r, 32'h0F);

    // R11 zero reads
    bus_read(5'h14, r); check("R11 0x14 zero", r, 0);
    bus_read(5'h0C, r); check("R11 tx reads zero", r, 0);
    bus_read(5'h1C, r); check("R11 unmapped zero", r, 0);

    finish_run();
  end
endmodule